// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of the device side of a three-wire serial EEPROM. It runs on a fast system clock and oversamples the chip select, serial clock and serial data input pins from a host controller. It answers on a serial output pin that carries its own output enable, so a tri-state pad or a bus resolver can be placed on top. Storage is a register array of 64 words of 16 bits. Reset clears the array to zero, so simulations start from a known state.

The host starts every command with a 1 bit, then sends a 2-bit opcode and a 6-bit word address, MSB first. A read answers with one leading zero and then the addressed word. While the host keeps the device selected and keeps clocking, the read runs on through the following words and wraps from the top of the array to word 0. A write carries a 16-bit data word. It is committed only when chip select drops, and then runs a store cycle of a fixed number of system clocks. While that cycle runs, a selected device reports busy or ready on the output pin. A write-enable latch, set and cleared by control commands, guards every write.

Top module: `serial_eeprom_model`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is cleared, and every word reads back as 0.
- R2: Input bits are taken on rising serial clock edges while chip select is high. Zero bits ahead of the 1 start bit are skipped. The start bit is followed by opcode bits [1:0] and then 6 address bits, all MSB first.
- R3: Read opcode 2'b10: on the rising edge that takes the last address bit, the output is enabled and drives 0. Each later rising edge presents the next bit of the addressed word, MSB first.
- R4: If the host keeps clocking after bit 0 of a word, the next rising edge presents the MSB of the word at address+1, with no zero in front of it.
- R5: The sequential read address wraps from word 63 to word 0.
- R6: Write opcode 2'b01 is followed by 16 data bits, MSB first. The falling edge of chip select after the last data bit replaces the whole addressed word with the new data, whatever the old contents were.
- R7: For BUSY_CYCLES system clocks after a committed write, a selected device drives the output enabled with value 0. After that time it drives 1 until chip select falls.
- R8: Control opcode 2'b00 sets the write-enable latch when address bits [5:4] are 2'b11, and clears it when they are 2'b00. A write sent while the latch is clear leaves memory unchanged and starts no busy cycle.
- R9: With chip select low the output enable is low. A command cut short by chip select falling has no effect, and the next command decodes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 1 | Device select from the host, active high |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial command, address and data bits from the host |
| ser_out | output | 1 | Serial read data or busy/ready status |
| ser_out_en | output | 1 | High when ser_out should be driven onto the wire |

## Verification
The bench goes after the leading zero of a read. A design that left it out, or repeated it on later words, would shift every compared word by one bit. It runs a sequential read across word 63. Wrapping to 64 or stopping there would return the wrong second word. It writes while the enable latch is clear and cuts a write short partway through its data. A design that stored anyway would change a word the bench expects to stay put. It polls the output during the store cycle and after it, which catches an inverted or missing busy flag. It also checks that stray zeros ahead of a start bit and aborted commands leave the next decode intact.

// File: rtl/seep_pkg.sv
package seep_pkg;

   localparam int OPC_W = 2;

   localparam logic [OPC_W-1:0] OPC_CTRL  = 2'b00;
   localparam logic [OPC_W-1:0] OPC_WRITE = 2'b01;
   localparam logic [OPC_W-1:0] OPC_READ  = 2'b10;

   localparam logic [1:0] CTRL_ENABLE  = 2'b11;
   localparam logic [1:0] CTRL_DISABLE = 2'b00;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CMD,
      PH_DATA,
      PH_READ,
      PH_HOLD,
      PH_SKIP
   } phase_t;

endpackage

// File: rtl/seep_pin_sync.sv
module seep_pin_sync #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_sel,
   input  logic ser_clk,
   input  logic ser_in,
   output logic sel_s,
   output logic din_s,
   output logic clk_rise,
   output logic sel_fall
);

   logic clk_s;
   logic clk_prev;
   logic sel_prev;

   generate
      if (STAGES < 1) begin : g_bad
         $error("seep_pin_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_s <= 1'b0;
               clk_s <= 1'b0;
               din_s <= 1'b0;
            end else begin
               sel_s <= chip_sel;
               clk_s <= ser_clk;
               din_s <= ser_in;
            end
         end
      end else begin : g_chain
         logic [STAGES-1:0] sel_p, clk_p, din_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_p <= '0;
               clk_p <= '0;
               din_p <= '0;
            end else begin
               sel_p <= {sel_p[STAGES-2:0], chip_sel};
               clk_p <= {clk_p[STAGES-2:0], ser_clk};
               din_p <= {din_p[STAGES-2:0], ser_in};
            end
         end
         assign sel_s = sel_p[STAGES-1];
         assign clk_s = clk_p[STAGES-1];
         assign din_s = din_p[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_prev <= 1'b0;
         sel_prev <= 1'b0;
      end else begin
         clk_prev <= clk_s;
         sel_prev <= sel_s;
      end
   end

   assign clk_rise = clk_s & ~clk_prev;
   assign sel_fall = sel_prev & ~sel_s;

   // R2
   single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_rise |=> !clk_rise);

endmodule

// File: rtl/seep_array.sv
module seep_array #(
   parameter int AW          = 6,
   parameter int DW          = 16,
   parameter bit RESET_CLEAR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   generate
      if (AW < 1 || AW > 12) begin : g_bad
         $error("seep_array: AW out of range");
      end
      if (RESET_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) words[i] <= '0;
            end else if (we) begin
               words[waddr] <= wdata;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (we) words[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = words[raddr];

endmodule

// File: rtl/seep_store_timer.sv
module seep_store_timer #(
   parameter int CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] left_q;

   generate
      if (CYCLES < 1) begin : g_bad
         $error("seep_store_timer: CYCLES must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left_q <= '0;
      else if (start)        left_q <= CW'(CYCLES);
      else if (left_q != '0) left_q <= left_q - CW'(1);
   end

   assign busy = (left_q != '0);

   // R7
   left_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= CW'(CYCLES));

endmodule

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model
   import seep_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int BUSY_CYCLES = 20,
   parameter int SYNC_STAGES = 1,
   parameter bit MEM_RESET   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_sel,
   input  logic ser_clk,
   input  logic ser_in,
   output logic ser_out,
   output logic ser_out_en
);

   localparam int CMD_W  = OPC_W + ADDR_W;
   localparam int MAXB   = (CMD_W > DATA_W) ? CMD_W : DATA_W;
   localparam int CNT_W  = $clog2(MAXB + 1);
   localparam int LEFT_W = $clog2(DATA_W + 1);

   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("serial_eeprom_model: ADDR_W must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("serial_eeprom_model: DATA_W must be at least 2");
      end
   endgenerate

   logic sel_s, din_s, clk_rise, sel_fall;

   seep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .chip_sel (chip_sel),
      .ser_clk  (ser_clk),
      .ser_in   (ser_in),
      .sel_s    (sel_s),
      .din_s    (din_s),
      .clk_rise (clk_rise),
      .sel_fall (sel_fall)
   );

   phase_t              ph_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [CMD_W-1:0]    cmd_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdat_q;
   logic [DATA_W-1:0]   sh_q;
   logic [LEFT_W-1:0]   left_q;
   logic                first_q;
   logic                dout_q;
   logic                wen_q;
   logic                stat_q;

   logic                mem_we;
   logic                busy;
   logic [ADDR_W-1:0]   rd_ptr;
   logic [DATA_W-1:0]   rd_word;
   logic [CMD_W-1:0]    cmd_full;
   logic [OPC_W-1:0]    cmd_op;
   logic [ADDR_W-1:0]   cmd_addr;
   logic [DATA_W-1:0]   wdat_full;

   assign cmd_full  = {cmd_q[CMD_W-2:0], din_s};
   assign cmd_op    = cmd_full[CMD_W-1 -: OPC_W];
   assign cmd_addr  = cmd_full[ADDR_W-1:0];
   assign wdat_full = {wdat_q[DATA_W-2:0], din_s};
   assign rd_ptr    = first_q ? addr_q : addr_q + ADDR_W'(1);
   assign mem_we    = sel_fall && (ph_q == PH_HOLD) && wen_q;

   seep_array #(.AW(ADDR_W), .DW(DATA_W), .RESET_CLEAR(MEM_RESET)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (addr_q),
      .wdata (wdat_q),
      .raddr (rd_ptr),
      .rdata (rd_word)
   );

   seep_store_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (mem_we),
      .busy  (busy)
   );

   // status mode: entered on a committed write, left once deselected and idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       stat_q <= 1'b0;
      else if (mem_we)                  stat_q <= 1'b1;
      else if (!sel_s && !busy)         stat_q <= 1'b0;
   end

   // command decoder and shifters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         cnt_q   <= '0;
         cmd_q   <= '0;
         addr_q  <= '0;
         wdat_q  <= '0;
         sh_q    <= '0;
         left_q  <= '0;
         first_q <= 1'b0;
         dout_q  <= 1'b0;
         wen_q   <= 1'b0;
      end else if (!sel_s) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else if (clk_rise && !stat_q) begin
         unique case (ph_q)
            PH_IDLE: begin
               if (din_s) begin
                  ph_q  <= PH_CMD;
                  cnt_q <= '0;
               end
            end
            PH_CMD: begin
               cmd_q <= cmd_full;
               cnt_q <= cnt_q + CNT_W'(1);
               if (cnt_q == CNT_W'(CMD_W - 1)) begin
                  cnt_q  <= '0;
                  addr_q <= cmd_addr;
                  unique case (cmd_op)
                     OPC_READ: begin
                        ph_q    <= PH_READ;
                        dout_q  <= 1'b0;
                        left_q  <= '0;
                        first_q <= 1'b1;
                     end
                     OPC_WRITE: begin
                        ph_q <= PH_DATA;
                     end
                     OPC_CTRL: begin
                        ph_q <= PH_SKIP;
                        if (cmd_addr[ADDR_W-1 -: 2] == CTRL_ENABLE)
                           wen_q <= 1'b1;
                        else if (cmd_addr[ADDR_W-1 -: 2] == CTRL_DISABLE)
                           wen_q <= 1'b0;
                     end
                     default: begin
                        ph_q <= PH_SKIP;
                     end
                  endcase
               end
            end
            PH_DATA: begin
               wdat_q <= wdat_full;
               cnt_q  <= cnt_q + CNT_W'(1);
               if (cnt_q == CNT_W'(DATA_W - 1)) begin
                  cnt_q <= '0;
                  ph_q  <= PH_HOLD;
               end
            end
            PH_READ: begin
               if (left_q == '0) begin
                  addr_q  <= rd_ptr;
                  first_q <= 1'b0;
                  dout_q  <= rd_word[DATA_W-1];
                  sh_q    <= rd_word << 1;
                  left_q  <= LEFT_W'(DATA_W - 1);
               end else begin
                  dout_q <= sh_q[DATA_W-1];
                  sh_q   <= sh_q << 1;
                  left_q <= left_q - LEFT_W'(1);
               end
            end
            default: begin
            end
         endcase
      end
   end

   assign ser_out_en = sel_s && ((ph_q == PH_READ) || stat_q);
   assign ser_out    = stat_q ? ~busy : dout_q;

   // R3
   dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_READ && $past(ph_q) != PH_READ) |-> !ser_out);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_READ && $past(ph_q) == PH_READ && addr_q != $past(addr_q))
         |-> addr_q == $past(addr_q) + ADDR_W'(1));

   // R6
   write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> busy);

   // R7
   busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sel_s) |-> (ser_out_en && !ser_out));

   // R9
   desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> (ph_q == PH_IDLE));

endmodule

// File: tb/tb_serial_eeprom_model.sv
`timescale 1ns/1ps
module tb_serial_eeprom_model;

   localparam int AW   = 6;
   localparam int DW   = 16;
   localparam int BUSY = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_sel = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_in = 1'b0;
   logic ser_out, ser_out_en;

   int n_vec = 0;
   int n_bad = 0;

   logic [DW-1:0] model [64];

   always #10 clk = ~clk;

   serial_eeprom_model #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_sel   (chip_sel),
      .ser_clk    (ser_clk),
      .ser_in     (ser_in),
      .ser_out    (ser_out),
      .ser_out_en (ser_out_en)
   );

   // {addr, data}
   localparam logic [21:0] VEC [8] = '{
      {6'd0,  16'hA5C3}, {6'd63, 16'h1234}, {6'd5,  16'hFFFF},
      {6'd6,  16'h0001}, {6'd3,  16'h8000}, {6'd42, 16'h5A5A},
      {6'd62, 16'hC0DE}, {6'd5,  16'h0F0F}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic d, output logic q, output logic qe);
      ser_in = d;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      q  = ser_out;
      qe = ser_out_en;
      ser_clk = 1'b0;
   endtask

   task automatic deselect();
      chip_sel = 1'b0;
      wait_clk(4);
   endtask

   // sends leading zeros, start bit, opcode, address; returns output at last bit
   task automatic send_cmd(input int lead, input logic [1:0] op, input logic [5:0] a,
                           output logic q, output logic qe);
      logic lq, le;
      chip_sel = 1'b1;
      wait_clk(2);
      for (int i = 0; i < lead; i++) pulse(1'b0, lq, le);
      pulse(1'b1, lq, le);
      for (int i = 1; i >= 0; i--) pulse(op[i], lq, le);
      for (int i = 5; i >= 0; i--) pulse(a[i], q, qe);
   endtask

   task automatic ctrl(input logic [5:0] a);
      logic q, qe;
      send_cmd(0, 2'b00, a, q, qe);
      deselect();
   endtask

   task automatic write_word(input logic [5:0] a, input logic [15:0] d, input bit ok);
      logic q, qe;
      send_cmd(0, 2'b01, a, q, qe);
      for (int i = 15; i >= 0; i--) pulse(d[i], q, qe);
      chip_sel = 1'b0;
      wait_clk(2);
      chip_sel = 1'b1;
      wait_clk(3);
      if (ok) begin
         // R7 busy polled
         check(ser_out_en === 1'b1 && ser_out === 1'b0, "R7 busy",
               {30'd0, ser_out_en, ser_out}, 32'h2);
         wait_clk(BUSY + 10);
         // R7 ready polled
         check(ser_out_en === 1'b1 && ser_out === 1'b1, "R7 ready",
               {30'd0, ser_out_en, ser_out}, 32'h3);
         model[a] = d;
      end else begin
         // R8 no status cycle
         check(ser_out_en === 1'b0, "R8 no busy", {31'd0, ser_out_en}, 32'h0);
      end
      deselect();
      wait_clk(BUSY + 4);
   endtask

   task automatic read_seq(input int lead, input logic [5:0] a, input int n,
                           input string req);
      logic q, qe;
      logic [15:0] w;
      logic [5:0] p;
      send_cmd(lead, 2'b10, a, q, qe);
      // R3 dummy zero
      check(qe === 1'b1 && q === 1'b0, "R3 dummy", {30'd0, qe, q}, 32'h2);
      p = a;
      for (int k = 0; k < n; k++) begin
         for (int i = 15; i >= 0; i--) begin
            pulse(1'b0, q, qe);
            w[i] = q;
         end
         check(w === model[p], req, {16'd0, w}, {16'd0, model[p]});
         p = p + 6'd1;
      end
      deselect();
   endtask

   initial begin
      logic q, qe;
      for (int i = 0; i < 64; i++) model[i] = '0;
      wait_clk(3);
      // R1 reset state
      check(ser_out_en === 1'b0, "R1 oe", {31'd0, ser_out_en}, 32'h0);
      rst_n = 1'b1;
      wait_clk(3);
      read_seq(0, 6'd42, 1, "R1 zero word");
      // R8 write before enable is dropped
      write_word(6'd42, 16'hBEEF, 1'b0);
      read_seq(0, 6'd42, 1, "R8 disabled at reset");
      ctrl(6'b110000);

      // vector table walk: R6 write and read-back, R2 decode
      for (int v = 0; v < 8; v++) begin
         write_word(VEC[v][21:16], VEC[v][15:0], 1'b1);
         read_seq(0, VEC[v][21:16], 1, "R6 write/read");
      end

      // R4 sequential read across several words
      read_seq(0, 6'd3, 4, "R4 sequential");
      // R5 wrap from 62 through 63 to 0 and 1
      read_seq(0, 6'd62, 4, "R5 wrap");
      // R2 leading zeros before the start bit
      read_seq(3, 6'd0, 1, "R2 leading zeros");

      // R8 disable, write dropped, re-enable
      ctrl(6'b001111);
      write_word(6'd3, 16'h7777, 1'b0);
      read_seq(0, 6'd3, 1, "R8 disabled write");
      ctrl(6'b111010);

      // R9 partial write aborted
      send_cmd(0, 2'b01, 6'd3, q, qe);
      for (int i = 0; i < 8; i++) pulse(1'b1, q, qe);
      chip_sel = 1'b0;
      wait_clk(3);
      check(ser_out_en === 1'b0, "R9 oe low", {31'd0, ser_out_en}, 32'h0);
      wait_clk(BUSY + 4);
      read_seq(0, 6'd3, 1, "R9 partial write");

      // R9 partial read aborted, then a clean read
      chip_sel = 1'b1;
      wait_clk(2);
      pulse(1'b1, q, qe);
      pulse(1'b1, q, qe);
      pulse(1'b0, q, qe);
      pulse(1'b1, q, qe);
      deselect();
      check(ser_out_en === 1'b0, "R9 abort read", {31'd0, ser_out_en}, 32'h0);
      read_seq(0, 6'd42, 1, "R9 after abort");

      // R6 overwrite with no erase
      write_word(6'd42, 16'h0FF0, 1'b1);
      read_seq(0, 6'd42, 1, "R6 overwrite");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule